// File: doc/BRIEF.md
# Repeated-Value Pulse Detector

This block watches a single-bit input that is already aligned to its clock. It raises a one-cycle pulse when a run of equal input values first reaches a length of two. The pulse appears in the clock cycle after the second equal sample, which makes the block a rising-edge Moore machine whose output is decoded from its state register alone.

The pulse fires once per run. Later equal samples in the same run stay silent until the input changes value and a new run reaches two samples. A synchronous, active-high reset returns the machine to an idle state. In that state no sample has been seen, so the first sample taken after reset can only start a run.

The state is held in a three-bit binary-coded register with seven used codes. The codes are idle, one zero seen, one one seen, zero pair detected, one pair detected, zero run continuing and one run continuing. Only the two detected states drive the output high.

Top module: `repeat_pulse_detector`

## Requirements
- R1: z is taken from registered state only. A change of w between clock edges leaves z unchanged until the next rising edge.
- R2: When the sample taken at edge t equals the sample at edge t-1, and the sample at edge t-2 was different or was not taken since reset, z is 1 in the cycle after edge t. That cycle is the one that ends at edge t+1.
- R3: z pulses once per run. While w keeps the same value for three or more samples, z stays 0 after the single pulse. It rises again only after w changes and the new value is sampled twice.
- R4: The first sample after reset only starts a run. z is 0 in the cycle after that sample, whatever the value of w.
- R5: While rst is 1 at a rising edge, z is 0 after that edge. A sample taken before reset never pairs with a sample taken after reset.
- R6: From reset, the input stream 001100011011100111111000010110 yields z = 001010100100100101000001000001 cycle for cycle. Character t is the value of w at edge t, or of z in the cycle that ends at edge t.
- R7: An input that changes value on every sample never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| w | input | 1 | Sampled data input, synchronous to clk |
| z | output | 1 | One-cycle pulse when a run of equal values reaches length two |

## Verification
The fixed 30-sample stream exercises runs of length one, two, three and six with both polarities, and its expected output is compared cycle for cycle. A strictly alternating stream shows that changes alone never fire. Long runs of each value show that the pulse is single and that it rearms on a value change. A reset in the middle of a run shows that samples are not paired across reset, and toggling w between edges shows that the output is registered. A long pseudo-random stream is checked against a run-length model in the bench, which sets detection at exactly length two apart from detection on any equal neighbours.

// File: rtl/repeat_pulse_detector.sv
module repeat_pulse_detector (
  input  logic clk,
  input  logic rst,
  input  logic w,
  output logic z
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ONE0  = 3'd1,
    S_ONE1  = 3'd2,
    S_HIT0  = 3'd3,
    S_HIT1  = 3'd4,
    S_RUN0  = 3'd5,
    S_RUN1  = 3'd6
  } state_t;

  state_t state, state_nxt;

  always_comb begin
    state_nxt = S_IDLE;
    case (state)
      S_IDLE:         state_nxt = w ? S_ONE1 : S_ONE0;
      S_ONE0:         state_nxt = w ? S_ONE1 : S_HIT0;
      S_ONE1:         state_nxt = w ? S_HIT1 : S_ONE0;
      S_HIT0, S_RUN0: state_nxt = w ? S_ONE1 : S_RUN0;
      S_HIT1, S_RUN1: state_nxt = w ? S_RUN1 : S_ONE0;
      default:        state_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nxt;
  end

  assign z = (state == S_HIT0) || (state == S_HIT1);

  // Independent sample history used only by the assertions
  logic       w_d1, w_d2;
  logic [1:0] n_smp;
  logic       pair_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      n_smp <= 2'd0;
      w_d1  <= 1'b0;
      w_d2  <= 1'b0;
    end else begin
      w_d1 <= w;
      w_d2 <= w_d1;
      if (n_smp != 2'd3) n_smp <= n_smp + 2'd1;
    end
  end

  assign pair_new = (n_smp != 2'd0) && (w == w_d1) && ((n_smp == 2'd1) || (w_d1 != w_d2));

  AST_PAIR_PULSES: assert property (@(posedge clk) disable iff (rst) pair_new |=> z); // R2
  AST_PULSE_HAS_PAIR: assert property (@(posedge clk) disable iff (rst) z |-> $past(pair_new)); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) z |=> !z); // R3
  AST_FIRST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (rst) (n_smp == 2'd0) |=> !z); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !z); // R5

endmodule

// File: tb/repeat_pulse_detector_bench.sv
module repeat_pulse_detector_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic w   = 1'b0;
  logic z;

  int n_checks = 0;
  int n_fail   = 0;
  int runlen   = 0;
  logic prevw  = 1'b0;

  always #5 clk = ~clk;

  repeat_pulse_detector u_repeat_pulse_detector (
    .clk(clk), .rst(rst), .w(w), .z(z)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Called at a falling edge: check z for this cycle, then drive the next sample
  task automatic step(input logic wv, input logic expz, input string tag);
    check(z, expz, tag);
    w = wv;
    @(negedge clk);
  endtask

  task automatic mstep(input logic wv, input string tag);
    logic e;
    e = (runlen == 2);
    step(wv, e, tag);
    if (runlen == 0 || wv != prevw) runlen = 1;
    else if (runlen < 3) runlen = runlen + 1;
    prevw = wv;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(z, 1'b0, "R5 reset state");
    rst = 1'b0;
    runlen = 0;
  endtask

  task automatic t_golden();
    logic [29:0] gw, gz;
    gw = 30'b001100011011100111111000010110;
    gz = 30'b001010100100100101000001000001;
    do_reset();
    for (int t = 0; t < 30; t++) step(gw[29-t], gz[29-t], "R6 golden stream");
    runlen = 0;
  endtask

  task automatic t_alternate();
    do_reset();
    for (int t = 0; t < 20; t++) mstep(t[0], "R7 alternating input");
    check(z, 1'b0, "R7 alternating tail");
  endtask

  task automatic t_first_sample();
    do_reset();
    mstep(1'b1, "R4 first sample");
    check(z, 1'b0, "R4 no pulse after first sample");
    do_reset();
    mstep(1'b0, "R4 first sample zero");
    mstep(1'b0, "R2 pair right after reset");
    check(z, 1'b1, "R2 pulse after first pair");
  endtask

  task automatic t_long_runs();
    do_reset();
    for (int t = 0; t < 8; t++) mstep(1'b1, "R3 long run of ones");
    for (int t = 0; t < 8; t++) mstep(1'b0, "R3 long run of zeros");
    mstep(1'b1, "R3 rearm");
    mstep(1'b1, "R2 new pair");
    check(z, 1'b1, "R3 pulse after rearm");
  endtask

  task automatic t_reset_midrun();
    do_reset();
    mstep(1'b0, "R5 before reset");
    rst = 1'b1;
    w = 1'b0;
    @(negedge clk);
    check(z, 1'b0, "R5 z low in reset");
    rst = 1'b0;
    runlen = 0;
    mstep(1'b0, "R5 first after reset");
    mstep(1'b1, "R5 no pair across reset");
    check(z, 1'b0, "R5 no pulse across reset");
  endtask

  task automatic t_midcycle();
    logic zs;
    do_reset();
    mstep(1'b1, "R1 setup");
    mstep(1'b1, "R1 setup pair");
    zs = z;
    #1 w = 1'b0;
    #1 w = 1'b1;
    #1 w = 1'b0;
    check(z, zs, "R1 z stable while w toggles");
    check(z, 1'b1, "R1 pulse held in its cycle");
    #1 w = 1'b1;
    @(negedge clk);
    prevw = 1'b1;
    runlen = 3;
    check(z, 1'b0, "R1 single pulse after toggles");
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    do_reset();
    for (int t = 0; t < 2000; t++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mstep(lfsr[0], "R2 R3 random stream");
    end
  endtask

  initial begin
    @(negedge clk);
    t_golden();
    t_alternate();
    t_first_sample();
    t_long_runs();
    t_reset_midrun();
    t_midcycle();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule